// File: doc/BRIEF.md
# Multi-Mode Addressable Bit Latch

This block keeps a bank of single-bit storage cells. A binary select word picks one cell, and a one-bit data input supplies the value to write. Two active-low controls, a clear and an enable, choose one of four modes. In write mode only the selected cell changes. In hold mode every cell keeps its value. In decode mode the selected cell takes the data bit and every other cell is forced off. In clear mode every cell is forced off.

The design is fully synchronous. Inputs are sampled on the rising clock edge, and the registered outputs show the result one cycle later. An output bit at 1 means that channel is sinking (on), and 0 means off. Bit i of the output bus belongs to select value i. The select word should only move while the enable is inactive. A one-cycle flag reports any select change that happens while the enable is active, so the system can catch a violation of that rule.

Top module: `addr_latch_bank`

## Requirements
- R1: With clr_n=1 and en_n=0 (write mode), at the next rising edge the output bit addressed by sel takes din, and all other output bits keep their values.
- R2: With clr_n=1 and en_n=1 (hold mode), all output bits keep their values at the next edge, whatever din and sel are.
- R3: With clr_n=0 and en_n=0 (decode mode), at the next edge the addressed output bit equals din and every other bit is 0.
- R4: With clr_n=0 and en_n=1 (clear mode), all output bits are 0 after the next edge, whatever din and sel are.
- R5: While rst (synchronous, active high) is sampled high, sink_on becomes all zeros and addr_err becomes 0 at that edge.
- R6: sel is plain binary with the MSB first, and output bit i belongs to sel value i. Each of the eight channels can be written on its own.
- R7: addr_err is 1 for exactly the cycle after an edge at which en_n=0 and sel differs from the sel sampled at the previous edge. It is 0 otherwise, including at the first edge after reset, where no earlier sel is on record.
- R8: After decode mode, hold mode keeps the single-hot pattern that decode mode produced.
- R9: Outputs change only on a rising edge. A change at the inputs between edges leaves sink_on unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Active-low clear control |
| en_n | input | 1 | Active-low enable control |
| sel | input | SEL_W (3) | Binary channel select |
| din | input | 1 | Data bit to store |
| sink_on | output | 2**SEL_W (8) | Registered channel states, 1 = sinking |
| addr_err | output | 1 | One-cycle flag for a select change while enabled |

## Verification
The bench builds the block with the default SEL_W of 3, which gives eight channels. With that size a directed walk can write each channel in turn and fill the whole bus, so a wrong bit mapping shows up as a wrong mask. The vector table steps through all four control combinations, with select changes placed both under an inactive and under an active enable. This reaches both polarities of the error flag and the hold that follows decode mode. Directed steps cover reset in the middle of a run with no earlier select on record, and input changes made between clock edges.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    // Encoding is {clr_n, en_n}
    typedef enum logic [1:0] {
        MODE_DECODE = 2'b00,
        MODE_CLEAR  = 2'b01,
        MODE_WRITE  = 2'b10,
        MODE_HOLD   = 2'b11
    } latch_mode_e;

    typedef struct packed {
        latch_mode_e mode;
        logic        wr_bit;
    } latch_ctrl_t;

    function automatic latch_mode_e decode_mode(input logic clr_n, input logic en_n);
        return latch_mode_e'({clr_n, en_n});
    endfunction

    function automatic logic next_cell(input latch_mode_e mode, input logic hit,
                                       input logic wr_bit, input logic cur);
        logic nxt;
        case (mode)
            MODE_WRITE:  nxt = hit ? wr_bit : cur;
            MODE_HOLD:   nxt = cur;
            MODE_DECODE: nxt = hit & wr_bit;
            default:     nxt = 1'b0;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lat_mode_dec.sv
module lat_mode_dec
    import addr_latch_pkg::*;
(
    input  logic        clr_n,
    input  logic        en_n,
    input  logic        din,
    output latch_ctrl_t ctrl
);
    always_comb begin
        ctrl.mode   = decode_mode(clr_n, en_n);
        ctrl.wr_bit = din;
    end
endmodule

// File: rtl/lat_sel_monitor.sv
module lat_sel_monitor #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    input  logic [SEL_W-1:0] sel,
    output logic             addr_err
);
    logic [SEL_W-1:0] sel_prev;
    logic             prev_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_prev   <= '0;
            prev_valid <= 1'b0;
            addr_err   <= 1'b0;
        end else begin
            sel_prev   <= sel;
            prev_valid <= 1'b1;
            addr_err   <= prev_valid && !en_n && (sel != sel_prev);
        end
    end
endmodule

// File: rtl/lat_bit_bank.sv
module lat_bit_bank
    import addr_latch_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int NUM_CH = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  latch_ctrl_t       ctrl,
    input  logic [SEL_W-1:0]  sel,
    output logic [NUM_CH-1:0] cells
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cell
        logic hit;
        assign hit = (sel == SEL_W'(ch));

        always_ff @(posedge clk) begin
            if (rst) cells[ch] <= 1'b0;
            else     cells[ch] <= next_cell(ctrl.mode, hit, ctrl.wr_bit, cells[ch]);
        end
    end
endmodule

// File: rtl/addr_latch_bank.sv
module addr_latch_bank
    import addr_latch_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr_n,
    input  logic                    en_n,
    input  logic [SEL_W-1:0]        sel,
    input  logic                    din,
    output logic [(1<<SEL_W)-1:0]   sink_on,
    output logic                    addr_err
);
    localparam int NUM_CH = 1 << SEL_W;

    latch_ctrl_t ctrl;

    lat_mode_dec u_dec (
        .clr_n (clr_n),
        .en_n  (en_n),
        .din   (din),
        .ctrl  (ctrl)
    );

    lat_bit_bank #(.SEL_W(SEL_W), .NUM_CH(NUM_CH)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .sel   (sel),
        .cells (sink_on)
    );

    lat_sel_monitor #(.SEL_W(SEL_W)) u_mon (
        .clk      (clk),
        .rst      (rst),
        .en_n     (en_n),
        .sel      (sel),
        .addr_err (addr_err)
    );
endmodule

// File: rtl/addr_latch_bank_chk.sv
module addr_latch_bank_chk #(
    parameter int SEL_W = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  clr_n,
    input logic                  en_n,
    input logic [SEL_W-1:0]      sel,
    input logic                  din,
    input logic [(1<<SEL_W)-1:0] sink_on,
    input logic                  addr_err
);
    localparam int NUM_CH = 1 << SEL_W;

    // Counts clean edges since reset, saturating
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    assert_write_sel_R1: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !en_n) |=> (sink_on[$past(sel)] == $past(din)));

    // R1: unaddressed bits unchanged
    assert_write_others_R1: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !en_n) |=>
        (((sink_on ^ $past(sink_on)) & ~(NUM_CH'(1) << $past(sel))) == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_n && en_n) |=> $stable(sink_on));

    assert_decode_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && !en_n) |=> ($onehot0(sink_on) && (sink_on[$past(sel)] == $past(din))));

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (!clr_n && en_n) |=> (sink_on == '0));

    assert_reset_R5: assert property (@(posedge clk)
        rst |=> ((sink_on == '0) && !addr_err));

    assert_err_set_R7: assert property (@(posedge clk) disable iff (rst)
        ((age != 2'd0) && !en_n && (sel != $past(sel))) |=> addr_err);

    assert_err_clr_R7: assert property (@(posedge clk) disable iff (rst)
        ((age == 2'd0) || en_n || (sel == $past(sel))) |=> !addr_err);
endmodule

bind addr_latch_bank addr_latch_bank_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .en_n     (en_n),
    .sel      (sel),
    .din      (din),
    .sink_on  (sink_on),
    .addr_err (addr_err)
);

// File: tb/sim_addr_latch_bank.sv
`timescale 1ns/1ps
module sim_addr_latch_bank;
    localparam int SEL_W = 3;
    localparam int NCH   = 1 << SEL_W;
    localparam int NVEC  = 23;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            clr_n = 1'b1;
    logic            en_n = 1'b1;
    logic [SEL_W-1:0] sel = '0;
    logic            din = 1'b0;
    logic [NCH-1:0]  sink_on;
    logic            addr_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    addr_latch_bank #(.SEL_W(SEL_W)) u0 (
        .clk(clk), .rst(rst), .clr_n(clr_n), .en_n(en_n),
        .sel(sel), .din(din), .sink_on(sink_on), .addr_err(addr_err)
    );

    // {clr_n, en_n, sel, din, expected err, expected sink_on}
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b1,1'b1,3'd0,1'b0,1'b0,8'h00},
        {1'b1,1'b1,3'd3,1'b0,1'b0,8'h00},
        {1'b1,1'b0,3'd3,1'b1,1'b0,8'h08},
        {1'b1,1'b1,3'd5,1'b0,1'b0,8'h08},
        {1'b1,1'b0,3'd5,1'b1,1'b0,8'h28},
        {1'b1,1'b0,3'd5,1'b0,1'b0,8'h08},
        {1'b1,1'b1,3'd7,1'b1,1'b0,8'h08},
        {1'b1,1'b0,3'd7,1'b1,1'b0,8'h88},
        {1'b1,1'b1,3'd0,1'b1,1'b0,8'h88},
        {1'b1,1'b0,3'd0,1'b1,1'b0,8'h89},
        {1'b0,1'b0,3'd0,1'b1,1'b0,8'h01},
        {1'b1,1'b1,3'd6,1'b0,1'b0,8'h01},
        {1'b0,1'b0,3'd6,1'b1,1'b0,8'h40},
        {1'b0,1'b0,3'd6,1'b0,1'b0,8'h00},
        {1'b1,1'b1,3'd2,1'b1,1'b0,8'h00},
        {1'b0,1'b0,3'd2,1'b1,1'b0,8'h04},
        {1'b0,1'b1,3'd2,1'b1,1'b0,8'h00},
        {1'b1,1'b0,3'd2,1'b1,1'b0,8'h04},
        {1'b0,1'b1,3'd4,1'b1,1'b0,8'h00},
        {1'b1,1'b0,3'd4,1'b1,1'b0,8'h10},
        {1'b1,1'b0,3'd1,1'b1,1'b1,8'h12},
        {1'b1,1'b0,3'd1,1'b0,1'b0,8'h10},
        {1'b1,1'b0,3'd1,1'b1,1'b0,8'h12}
    };

    task automatic check(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic e, input logic [SEL_W-1:0] s, input logic d);
        clr_n = c; en_n = e; sel = s; din = d;
    endtask

    task automatic step_check(input string req, input logic [NCH-1:0] exp_out, input logic exp_err);
        @(negedge clk);
        check(req, sink_on, exp_out);
        check({req, " R7 flag"}, NCH'(addr_err), NCH'(exp_err));
    endtask

    function automatic string mode_tag(input logic c, input logic e);
        case ({c, e})
            2'b10:   return "R1 write";
            2'b11:   return "R2 hold";
            2'b00:   return "R3 decode";
            default: return "R4 clear";
        endcase
    endfunction

    initial begin
        logic [NCH-1:0] model;
        repeat (3) @(negedge clk);
        check("R5 reset outputs", sink_on, '0);
        check("R5 reset flag", NCH'(addr_err), '0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][14], VEC[i][13], VEC[i][12:10], VEC[i][9]);
            step_check($sformatf("%s vec %0d", mode_tag(VEC[i][14], VEC[i][13]), i),
                       VEC[i][7:0], VEC[i][8]);
        end
        // state 0x12, last sel 1

        // R9: outputs hold between edges
        drive(1, 1, 3'd6, 1);
        step_check("R9 setup hold", 8'h12, 0);
        drive(1, 0, 3'd6, 1);
        #1 check("R9 no change before edge", sink_on, 8'h12);
        step_check("R9 after edge", 8'h52, 0);

        // R8: decode then hold keeps one-hot
        drive(0, 0, 3'd6, 1);
        step_check("R8 decode", 8'h40, 0);
        for (int k = 0; k < 3; k++) begin
            drive(1, 1, 3'(k + 1), 1'(k));
            step_check("R8 hold after decode", 8'h40, 0);
        end

        // R6: each channel by address
        drive(0, 1, 3'd0, 0);
        step_check("R4 clear before walk", 8'h00, 0);
        model = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            drive(1, 1, 3'(ch), 1);
            step_check("R6 hold stage", model, 0);
            drive(1, 0, 3'(ch), 1);
            model[ch] = 1'b1;
            step_check($sformatf("R6 channel %0d", ch), model, 0);
        end

        // R7: select moves while enabled
        drive(1, 0, 3'd3, 0);
        step_check("R7 change while enabled", 8'hF7, 1);
        drive(1, 0, 3'd3, 0);
        step_check("R7 pulse ends", 8'hF7, 0);

        // R5: reset mid-run, then no history at first edge
        rst = 1'b1;
        drive(1, 0, 3'd0, 1);
        step_check("R5 mid-run reset", 8'h00, 0);
        rst = 1'b0;
        drive(1, 0, 3'd5, 1);
        step_check("R7 first edge after reset", 8'h20, 0);
        drive(1, 0, 3'd5, 0);
        step_check("R1 clear written bit", 8'h00, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule